// File: doc/BRIEF.md
# Complex NCO Up-Mixer

This block moves a complex baseband stream up to an intermediate frequency. A 32-bit phase accumulator advances by a programmable tuning word each time a sample arrives. A 16-bit phase offset is added to the accumulator phase, and the sum addresses a sine/cosine table that stores only a quarter wave. Each incoming I/Q pair is rotated by the resulting angle. The block produces two outputs: `out_a = I·cos − Q·sin` and `out_b = I·sin + Q·cos`. Both are rounded and saturated back to the input width. The output frequency equals the tuning word times the sample rate, divided by 2^32.

Configuration is written one byte at a time on a small register port. The control byte turns the oscillator on or off and selects a low-power mode. In low-power mode only the five most significant bits of the tuning word and of the phase offset are used. While the oscillator is off, the accumulator is held at zero and samples pass through unchanged. Both paths have the same fixed latency.

Top module: `nco_iq_mixer`

## Requirements
- R1: After reset, `out_valid`, `out_a` and `out_b` are 0, and every configuration byte is 0, which means the oscillator is off.
- R2: A write on `cfg_wr` stores `cfg_data` at `cfg_addr` as follows:
  - addresses 0 to 3 hold the tuning word, least significant byte first;
  - addresses 4 and 5 hold the phase offset, least significant byte first;
  - address 6 is the control byte: bit 0 turns the oscillator on, bit 1 selects low power.
- R3: While the oscillator is off, the accumulator is held at zero and each output equals its input (`out_a` = `in_i`, `out_b` = `in_q`). When the oscillator is turned back on, the first sample uses accumulator phase 0.
- R4: While the oscillator is on, the accumulator adds the effective tuning word once for each cycle with `in_valid` high and wraps modulo 2^32. Cycles without `in_valid` leave it unchanged. Each sample uses the accumulator value from before its own addition.
- R5: The table angle is the top 16 accumulator bits plus the effective phase offset, modulo 2^16. Bits 15..4 of that sum form a 12-bit table index n.
- R6: The table values are sin = round(8191·sin(2π(n+0.5)/4096)) and cos = round(8191·cos(2π(n+0.5)/4096)), rounded half away from zero. Only a quarter wave of 1024 entries is stored.
- R7: `out_a` = (I·cos − Q·sin + 4096) >> 13, using an arithmetic shift.
- R8: `out_b` = (I·sin + Q·cos + 4096) >> 13, using an arithmetic shift.
- R9: Results above 8191 give 8191, and results below −8192 give −8192.
- R10: In low-power mode, the tuning word is reduced to bits 31..27 and the phase offset to bits 15..11. All lower bits are treated as zero.
- R11: `out_valid` rises exactly 3 cycles after `in_valid` and carries that sample's result. All samples are 14-bit two's complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 3 | Configuration byte address |
| cfg_data | input | 8 | Configuration byte value |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 14 | In-phase input sample |
| in_q | input | 14 | Quadrature input sample |
| out_valid | output | 1 | Output sample strobe |
| out_a | output | 14 | I·cos − Q·sin result |
| out_b | output | 14 | I·sin + Q·cos result |

## Verification
The accumulator is the only long-lived state. A wrong step, a missed wrap or a phase that is not cleared corrupts every later sample, and the error grows over time. A stuck accumulator or a wrong offset is visible in the first output after the bad update, three cycles later. A wrong quadrant or mirror in the table flips the sign of single outputs or swaps them, but only at certain angles. For that reason the bench sweeps phases across all four quadrants, and also drives the exact 45-degree case, where the extreme inputs force saturation.

// File: rtl/nco_iq_mixer.sv
module nco_iq_mixer #(
  parameter int DW     = 14,
  parameter int FW     = 32,
  parameter int PW     = 16,
  parameter int LUT_AW = 10,
  parameter int TW     = 14,
  parameter int LPB    = 5,
  parameter int AW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [7:0]           cfg_data,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);
  localparam int IDXW  = LUT_AW + 2;
  localparam int DEPTH = 2 ** LUT_AW;
  localparam int AMP   = 2 ** (TW - 1) - 1;
  localparam int SHIFT = TW - 1;
  localparam int SW    = DW + TW + 1;
  localparam int FB    = FW / 8;
  localparam int PB    = PW / 8;
  localparam int CTRL  = FB + PB;
  localparam logic signed [SW-1:0] MAXV = SW'((2 ** (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (SHIFT - 1));
  localparam logic [FW-1:0] FMASK = {{LPB{1'b1}}, {(FW-LPB){1'b0}}};
  localparam logic [PW-1:0] PMASK = {{LPB{1'b1}}, {(PW-LPB){1'b0}}};

  function automatic int quarter_val(int k);
    real a;
    a = $sin(2.0 * 3.141592653589793 * (k + 0.5) / (4.0 * DEPTH));
    return $rtoi(a * AMP + 0.5);
  endfunction

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] r;
    r = (x + HALF) >>> SHIFT;
    if (r > MAXV)      return DW'(MAXV);
    else if (r < MINV) return DW'(MINV);
    else               return DW'(r);
  endfunction

  // configuration bytes
  logic [FW-1:0] fw_reg;
  logic [PW-1:0] ph_reg;
  logic          ctrl_en, ctrl_lp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fw_reg  <= '0;
      ph_reg  <= '0;
      ctrl_en <= 1'b0;
      ctrl_lp <= 1'b0;
    end else if (cfg_wr) begin
      for (int b = 0; b < FB; b++)
        if (cfg_addr == AW'(b)) fw_reg[8*b +: 8] <= cfg_data;
      for (int b = 0; b < PB; b++)
        if (cfg_addr == AW'(FB + b)) ph_reg[8*b +: 8] <= cfg_data;
      if (cfg_addr == AW'(CTRL)) begin
        ctrl_en <= cfg_data[0];
        ctrl_lp <= cfg_data[1];
      end
    end
  end

  wire [FW-1:0] fw_eff = ctrl_lp ? (fw_reg & FMASK) : fw_reg;
  wire [PW-1:0] ph_eff = ctrl_lp ? (ph_reg & PMASK) : ph_reg;

  // phase accumulator
  logic [FW-1:0] acc;
  always_ff @(posedge clk) begin
    if (!rst_n || !ctrl_en) acc <= '0;
    else if (in_valid)      acc <= acc + fw_eff;
  end

  wire [PW-1:0] ph_sum = acc[FW-1 -: PW] + ph_eff;

  // stage 1: capture sample and table index
  logic                 v1, byp1;
  logic signed [DW-1:0] i1, q1;
  logic [IDXW-1:0]      idx1;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; byp1 <= 1'b1; i1 <= '0; q1 <= '0; idx1 <= '0;
    end else begin
      v1   <= in_valid;
      byp1 <= !ctrl_en;
      i1   <= in_i;
      q1   <= in_q;
      idx1 <= ph_sum[PW-1 -: IDXW];
    end
  end

  // quarter-wave table
  logic [TW-2:0] rom [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = (TW-1)'(quarter_val(k));
  end

  wire [1:0]        quad = idx1[IDXW-1 -: 2];
  wire [LUT_AW-1:0] kk   = idx1[LUT_AW-1:0];
  wire signed [TW-1:0] t_d = {1'b0, rom[kk]};
  wire signed [TW-1:0] t_m = {1'b0, rom[~kk]};
  logic signed [TW-1:0] sin_l, cos_l;
  always_comb begin
    case (quad)
      2'd0:    begin sin_l =  t_d; cos_l =  t_m; end
      2'd1:    begin sin_l =  t_m; cos_l = -t_d; end
      2'd2:    begin sin_l = -t_d; cos_l = -t_m; end
      default: begin sin_l = -t_m; cos_l =  t_d; end
    endcase
  end

  // stage 2: registered trig values
  logic                 v2, byp2;
  logic signed [DW-1:0] i2, q2;
  logic signed [TW-1:0] s2, c2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; byp2 <= 1'b1; i2 <= '0; q2 <= '0; s2 <= '0; c2 <= '0;
    end else begin
      v2 <= v1; byp2 <= byp1; i2 <= i1; q2 <= q1; s2 <= sin_l; c2 <= cos_l;
    end
  end

  // stage 3: complex rotation, round, saturate
  wire signed [SW-1:0] sum_a = SW'(i2 * c2) - SW'(q2 * s2);
  wire signed [SW-1:0] sum_b = SW'(i2 * s2) + SW'(q2 * c2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_a <= '0; out_b <= '0;
    end else begin
      out_valid <= v2;
      out_a     <= byp2 ? i2 : rnd_sat(sum_a);
      out_b     <= byp2 ? q2 : rnd_sat(sum_b);
    end
  end

  assert_valid_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && in_valid) |-> ##3 (out_a == $past(in_i, 3) && out_b == $past(in_q, 3)));
  assert_phase_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> acc == '0);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !in_valid && !(cfg_wr && cfg_addr == AW'(CTRL))) |=> $stable(acc));
  assert_lowpower_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && ctrl_lp && in_valid && !(cfg_wr && cfg_addr == AW'(CTRL)))
      |=> acc[FW-LPB-1:0] == $past(acc[FW-LPB-1:0]));
endmodule

// File: tb/nco_iq_mixer_bench.sv
module nco_iq_mixer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_data = '0;
  logic in_valid = 1'b0;
  logic signed [13:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [13:0] out_a, out_b;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nco_iq_mixer u_nco_iq_mixer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b));

  // bench model state
  logic [31:0] m_fw = '0, m_acc = '0;
  logic [15:0] m_ph = '0;
  bit m_en = 0, m_lp = 0;
  int ea[$], eb[$];
  string et[$];

  function automatic int trig(int idx, bit use_cos);
    real a, v;
    a = 2.0 * 3.141592653589793 * (idx + 0.5) / 4096.0;
    v = 8191.0 * (use_cos ? $cos(a) : $sin(a));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int rsat(longint x);
    longint r;
    r = (x + 4096) >>> 13;
    if (r > 8191) r = 8191;
    if (r < -8192) r = -8192;
    return int'(r);
  endfunction

  function automatic int iabs(int x);
    return x < 0 ? -x : x;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'(addr); cfg_data = 8'(data);
    if (addr < 4) m_fw[8*addr +: 8] = 8'(data);
    else if (addr < 6) m_ph[8*(addr-4) +: 8] = 8'(data);
    else begin m_en = data[0]; m_lp = data[1]; if (!m_en) m_acc = '0; end
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_fw(logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(b, v[8*b +: 8]);
  endtask

  task automatic set_ph(logic [15:0] v);
    wr(4, v[7:0]); wr(5, v[15:8]);
  endtask

  task automatic send(int i, int q, string tag);
    logic [31:0] fe;
    logic [15:0] pe, ps;
    int idx, s, c;
    fe = m_lp ? (m_fw & 32'hF800_0000) : m_fw;
    pe = m_lp ? (m_ph & 16'hF800) : m_ph;
    in_valid = 1'b1; in_i = 14'(i); in_q = 14'(q);
    if (!m_en) begin
      ea.push_back(i); eb.push_back(q);
    end else begin
      ps = m_acc[31:16] + pe;
      idx = int'(ps[15:4]);
      s = trig(idx, 1'b0); c = trig(idx, 1'b1);
      ea.push_back(rsat(longint'(i) * c - longint'(q) * s));
      eb.push_back(rsat(longint'(i) * s + longint'(q) * c));
      m_acc = m_acc + fe;
    end
    et.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rnd_burst(int n, string tag);
    for (int k = 0; k < n; k++) begin
      send($signed(14'($urandom)), $signed(14'($urandom)), tag);
      if ($urandom % 4 == 0) repeat ($urandom % 3 + 1) @(negedge clk);
    end
  endtask

  task automatic drain;
    repeat (6) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (ea.size() == 0) check("R11 unexpected out_valid", 1, 0);
      else begin
        string t;
        int xa, xb;
        t = et.pop_front(); xa = ea.pop_front(); xb = eb.pop_front();
        check({t, " out_a"}, int'(out_a), xa);
        check({t, " out_b"}, int'(out_b), xb);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 out_a after reset", int'(out_a), 0);
    check("R1 out_b after reset", int'(out_b), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: default configuration is off, so samples pass through
    send(1234, -777, "R1 R3 default bypass");
    rnd_burst(20, "R3 bypass random");
    drain();

    // R11: single pulse latency
    send(100, 200, "R11 single sample");
    check("R11 out_valid cycle+1", int'(out_valid), 0);
    @(negedge clk);
    check("R11 out_valid cycle+2", int'(out_valid), 0);
    @(negedge clk);
    check("R11 out_valid cycle+3", int'(out_valid), 1);
    drain();

    // R6 R7 R8: zero frequency and phase, table index 0
    wr(6, 1);
    send(4000, 0, "R6 R7 R8 index0");
    send(0, 4000, "R6 R7 R8 index0 q");
    drain();

    // R2 R4 R5: random words, random sample gaps
    for (int r = 0; r < 8; r++) begin
      set_fw($urandom);
      set_ph(16'($urandom));
      rnd_burst(150, "R2 R4 R5 R6 R7 R8 random");
    end
    drain();

    // R4: wrap modulo 2^32 with a large step
    set_fw(32'hC000_0001);
    set_ph(16'h0000);
    rnd_burst(60, "R4 wrap");
    drain();

    // R3: disable clears phase, re-enable starts at zero
    wr(6, 0);
    send(-5000, 6000, "R3 disabled passthrough");
    wr(6, 1);
    set_fw(32'h0);
    set_ph(16'h2000);
    // R9: 45 degrees with extreme inputs drives out_a past the range
    send(-8192, 8191, "R9 saturate low");
    send(8191, -8192, "R9 saturate high");
    send(8191, 8191, "R9 near-limit");
    drain();

    // R10: low-power masking of both words
    wr(6, 3);
    set_fw(32'h1234_5678);
    set_ph(16'h0FFF);
    rnd_burst(100, "R10 low power");
    set_fw(32'hF7FF_FFFF);
    set_ph(16'h07FF);
    rnd_burst(100, "R10 low power masked");
    drain();

    // R4: back to full precision, gaps do not advance
    wr(6, 1);
    set_fw(32'h0123_4567);
    for (int k = 0; k < 40; k++) begin
      send(3000, -2000, "R4 idle gaps");
      repeat (k % 5) @(negedge clk);
    end
    rnd_burst(300, "R4 R5 R7 R8 random tail");
    drain();

    check("R11 all samples delivered", ea.size(), 0);
    check("R6 table peak", iabs(trig(1023, 1'b0)), 8191);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule